// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block times an external digital signal against the system clock. A 16-bit up-counter advances on a selectable tick strobe. When the measured input shows an active edge, the counter's value is copied into a capture register and the counter restarts from zero. Depending on the configured measurement mode, the captured value is either the period between like edges or the width of each high and low phase.

Software programs a small configuration register. That register holds the measurement mode, the tick source and a read-only overflow flag. A separate run input gates all counting. The measured input is first resynchronised to the system clock. Each capture and each counter wrap raises a one-cycle interrupt request. The interrupt for the first active edge after counting starts is withheld, because that edge only marks the start of the first interval. The tick strobes come from a prescaler outside the block, and the interrupt controller and the bus decoding also sit outside it.

Top module: `pulse_capture_timer`

## Requirements
- R1: While `run_i` is 1, the counter rises by one on every clock where the selected tick strobe is 1. While `run_i` is 0, the counter holds its value.
- R2: Measurement mode 00 (configuration bits [1:0]) acts on each falling edge of the synchronised input while running. On such an edge, `capture_o` takes the count and the counter restarts at 0. The captured value is the number of ticks between two consecutive falling edges, not counting any tick that falls on the capture cycle itself.
- R3: Mode 01 captures and clears in the same way on rising edges only.
- R4: Mode 10 captures and clears on every edge of either polarity, so each capture measures one high phase or one low phase.
- R5: Mode 11 is reserved. In this mode no edge captures, clears the counter or raises `irq_o`.
- R6: Configuration bits [3:2] pick the tick source: 00 selects `tick_fast_i`, 01 selects `tick_div8_i`, 10 selects `tick_div32_i` and 11 selects `tick_slow_i`.
- R7: `irq_o` pulses for one cycle, in the cycle in which `capture_o` shows the new capture. The first active edge after `run_i` rises captures but raises no request.
- R8: A tick taken while the counter holds all ones wraps the counter to 0. In the same cycle it sets the overflow flag (`cfg_rdata_o[4]`) and raises `irq_o`.
- R9: A configuration write clears the overflow flag only if `run_i` is 1 and a tick has been counted since the flag was set, or a tick occurs in the cycle of the write. An earlier write, or a write while stopped, leaves the flag set. A new overflow in the same cycle as a clearing write wins. The write path has no bit that can set the flag.
- R10: `capture_o`, `irq_o` and `cfg_rdata_o` are 0 after reset, and `capture_o` stays 0 until the first capture. An input change applied before clock edge k captures on edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Count enable (start/stop) |
| tick_fast_i | input | 1 | Tick strobe, source 00 |
| tick_div8_i | input | 1 | Tick strobe, source 01 |
| tick_div32_i | input | 1 | Tick strobe, source 10 |
| tick_slow_i | input | 1 | Tick strobe, source 11 |
| meas_i | input | 1 | Asynchronous signal under measurement |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Write data: [1:0] mode, [3:2] source |
| cfg_rdata_o | output | 5 | Readback: [1:0] mode, [3:2] source, [4] overflow flag |
| capture_o | output | 16 | Last captured count |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that the tick strobes and `run_i` are synchronous to `clk`. They also assume that the configuration is not rewritten while an edge is still travelling through the synchroniser. The bench changes the mode and the source only after stopping the timer and letting the input settle for several cycles. The measured input is held for at least four cycles per phase, so that each edge is seen exactly once. The overflow case drives the chosen strobe for exactly 65536 cycles and then releases it, so the bench knows precisely which writes come before or after the next tick.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic [1:0] {
        MEAS_FALL = 2'b00,
        MEAS_RISE = 2'b01,
        MEAS_BOTH = 2'b10,
        MEAS_RSVD = 2'b11
    } meas_mode_e;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_SLOW  = 2'b11
    } tick_src_e;

    typedef struct packed {
        tick_src_e  src;
        meas_mode_e mode;
    } cfg_t;

    localparam int NUM_SRC = 4;
endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/pcap_tick_sel.sv
module pcap_tick_sel
    import pcap_pkg::*;
(
    input  logic [NUM_SRC-1:0] strobes_i,
    input  tick_src_e          src_i,
    output logic               tick_o
);
    always_comb begin
        tick_o = strobes_i[src_i];
    end
endmodule

// File: rtl/pcap_core.sv
module pcap_core
    import pcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             cfg_wr_i,
    input  logic [3:0]       cfg_wdata_i,
    output tick_src_e        src_o,
    output logic [4:0]       cfg_rdata_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             ovf;
        logic             ovf_aged;
        logic             armed;
        logic             irq;
    } state_t;

    state_t st_d, st_q;
    logic   edge_hit;
    logic   wrap_hit;
    logic   clr_ok;

    always_comb begin
        unique case (st_q.cfg.mode)
            MEAS_FALL: edge_hit = fall_i;
            MEAS_RISE: edge_hit = rise_i;
            MEAS_BOTH: edge_hit = rise_i | fall_i;
            default:   edge_hit = 1'b0;
        endcase
        wrap_hit = run_i & tick_i & ~edge_hit & (st_q.cnt == CNT_MAX);
        clr_ok   = cfg_wr_i & run_i & st_q.ovf & (st_q.ovf_aged | tick_i);

        st_d     = st_q;
        st_d.irq = 1'b0;

        if (run_i) begin
            if (edge_hit) begin
                st_d.cap   = st_q.cnt;
                st_d.cnt   = '0;
                st_d.irq   = st_q.armed;
                st_d.armed = 1'b1;
            end else if (tick_i) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            st_d.armed = 1'b0;
        end

        if (run_i && tick_i && st_q.ovf) st_d.ovf_aged = 1'b1;
        if (clr_ok) begin
            st_d.ovf      = 1'b0;
            st_d.ovf_aged = 1'b0;
        end
        if (wrap_hit) begin
            st_d.ovf      = 1'b1;
            st_d.ovf_aged = 1'b0;
            st_d.irq      = 1'b1;
        end

        if (cfg_wr_i) begin
            st_d.cfg.mode = meas_mode_e'(cfg_wdata_i[1:0]);
            st_d.cfg.src  = tick_src_e'(cfg_wdata_i[3:2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o       = st_q.cfg.src;
    assign cfg_rdata_o = {st_q.ovf, st_q.cfg.src, st_q.cfg.mode};
    assign capture_o   = st_q.cap;
    assign irq_o       = st_q.irq;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !edge_hit && st_q.cnt != CNT_MAX)
        |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.cnt));

    assert_capture_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && edge_hit) |=> (st_q.cnt == '0 && st_q.cap == $past(st_q.cnt)));

    assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.mode == MEAS_RSVD) |=> $stable(st_q.cap));

    assert_first_edge_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && edge_hit && !st_q.armed) |=> !st_q.irq);

    assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_hit |=> (st_q.cnt == '0 && st_q.ovf && st_q.irq));

    assert_flag_kept_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !run_i) |=> st_q.ovf);
endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
    import pcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_fast_i,
    input  logic             tick_div8_i,
    input  logic             tick_div32_i,
    input  logic             tick_slow_i,
    input  logic             meas_i,
    input  logic             cfg_wr_i,
    input  logic [3:0]       cfg_wdata_i,
    output logic [4:0]       cfg_rdata_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             irq_o
);
    logic      rise, fall, tick;
    tick_src_e src;

    pcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (meas_i),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    pcap_tick_sel u_tick (
        .strobes_i ({tick_slow_i, tick_div32_i, tick_div8_i, tick_fast_i}),
        .src_i     (src),
        .tick_o    (tick)
    );

    pcap_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .tick_i      (tick),
        .rise_i      (rise),
        .fall_i      (fall),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .src_o       (src),
        .cfg_rdata_o (cfg_rdata_o),
        .capture_o   (capture_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/tb_pulse_capture_timer.sv
`timescale 1ns/1ps
module tb_pulse_capture_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        tick_fast_i = 1'b0, tick_div8_i = 1'b0, tick_div32_i = 1'b0, tick_slow_i = 1'b0;
    logic        meas_i = 1'b1;
    logic        cfg_wr_i = 1'b0;
    logic [3:0]  cfg_wdata_i = '0;
    logic [4:0]  cfg_rdata_o;
    logic [15:0] capture_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    pulse_capture_timer dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [1:0] mode, input logic [1:0] src);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_wdata_i = {src, mode};
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    // Monitor: every irq pops one expected item (bit16 = overflow event)
    always @(negedge clk) begin
        if (rst_n && irq_o && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R5 unexpected irq", 1, 0);
            end else begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[16]) check(cfg_rdata_o[4] == 1'b1, t, cfg_rdata_o[4], 1);
                else       check(capture_o == e[15:0], t, capture_o, e[15:0]);
            end
        end
    end

    // Driver: run one measurement; pushes expected captures (first edge excluded)
    task automatic run_mode(input logic [1:0] mode, input logic [1:0] src, input bit counts,
                            input int a, input int b, input int n, input string tag);
        int  t = 0;
        int  last = 0;
        bit  first = 1'b1;
        @(negedge clk); run_i = 1'b0;
        wr_cfg(mode, src);
        meas_i = 1'b1;
        hold(6);
        run_i = 1'b1;
        hold(3);
        for (int k = 0; k < 2 * n; k++) begin
            bit lvl = k[0];
            bit act = (mode == 2'b00 && !lvl) || (mode == 2'b01 && lvl) || (mode == 2'b10);
            if (act) begin
                if (!first) begin
                    exp_q.push_back({1'b0, counts ? 16'(t - last - 1) : 16'd0});
                    tag_q.push_back(tag);
                end
                first = 1'b0;
                last = t;
            end
            meas_i = lvl;
            hold(lvl ? b : a);
            t += lvl ? b : a;
        end
        hold(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] cap_keep;
        hold(3);
        rst_n = 1'b1;
        hold(2);
        check(capture_o == 16'd0, "R10 capture after reset", capture_o, 0);
        check(irq_o == 1'b0, "R10 irq after reset", irq_o, 0);
        check(cfg_rdata_o == 5'd0, "R10 cfg after reset", cfg_rdata_o, 0);

        // R8: overflow on source 01 (tick_div8_i), reserved mode so no capture
        wr_cfg(2'b11, 2'b01);
        run_i = 1'b1;
        exp_q.push_back({1'b1, 16'd0}); tag_q.push_back("R8 overflow irq and flag");
        tick_div8_i = 1'b1;
        hold(65536);
        tick_div8_i = 1'b0;
        hold(2);
        check(cfg_rdata_o[4] == 1'b1, "R8 flag set", cfg_rdata_o[4], 1);
        check(capture_o == 16'd0, "R10 no capture yet", capture_o, 0);

        // R9: write before a later tick leaves flag set
        wr_cfg(2'b11, 2'b01);
        check(cfg_rdata_o[4] == 1'b1, "R9 early write keeps flag", cfg_rdata_o[4], 1);
        tick_div8_i = 1'b1; hold(1); tick_div8_i = 1'b0; hold(1);
        run_i = 1'b0;
        wr_cfg(2'b11, 2'b01);
        check(cfg_rdata_o[4] == 1'b1, "R9 write while stopped keeps flag", cfg_rdata_o[4], 1);
        run_i = 1'b1;
        wr_cfg(2'b11, 2'b01);
        check(cfg_rdata_o[4] == 1'b0, "R9 aged write clears flag", cfg_rdata_o[4], 0);
        check(cfg_rdata_o[3:0] == 4'b0111, "R6 cfg readback", cfg_rdata_o[3:0], 7);

        // Edge measurements
        tick_fast_i = 1'b1; tick_slow_i = 1'b1;
        run_mode(2'b00, 2'b00, 1'b1, 5, 7, 4, "R2 falling period");
        run_mode(2'b01, 2'b00, 1'b1, 4, 9, 4, "R3 rising period");
        run_mode(2'b10, 2'b00, 1'b1, 6, 10, 3, "R4 width both edges");
        run_mode(2'b00, 2'b11, 1'b1, 5, 5, 3, "R6 slow source");
        run_mode(2'b00, 2'b10, 1'b0, 5, 5, 3, "R6 idle div32 source R1");

        // R5: reserved mode ignores edges
        cap_keep = capture_o;
        run_mode(2'b11, 2'b00, 1'b1, 5, 5, 0, "R5");
        for (int k = 0; k < 6; k++) begin
            meas_i = k[0];
            hold(6);
        end
        hold(6);
        check(capture_o == cap_keep, "R5 reserved mode no capture", capture_o, cap_keep);

        check(exp_q.size() == 0, "R7 all expected irqs seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule